// File: doc/BRIEF.md
# Playback Sample FIFO with Burst Request

This block is one playback channel of a serial audio link controller. A bus master writes 32-bit words into a small word FIFO. Each word packs two 16-bit audio samples. Whenever the frame logic asks for this channel's slot, the block returns one 20-bit slot value. The lower half of the head word goes out first, then the upper half, and the word is retired only after its upper half has been sent. Each sample sits in the top 16 bits of the slot, and the bottom 4 bits are zero.

The block raises a room flag when the FIFO has space for a whole burst. Because the burst size equals the depth, this means the FIFO is empty. On that flag it requests a transfer from a DMA engine and holds the request until a one-cycle acknowledge arrives. It flags an underrun when a slot is asked for with no sample available. It flags an overrun when a word arrives at a full FIFO, and that word is dropped. Clearing the channel enable empties the FIFO and resets the half-word selector.

The depth is a build-time choice of 4, 8 or 16 words, and the burst size always equals the depth. The reset input is asynchronous and active-low, and it is released through a two-stage synchronizer.

Top module: `pcm_out_chan`

## Requirements
- R1: For the first sampled cycle after reset, slot_data is zero. underrun, overrun, room_flag and dma_req are all low. This holds while chan_en is low.
- R2: The samples of one word leave in this order: bits [15:0] on the first slot request, bits [31:16] on the second. The word is retired after the second request.
- R3: A slot returned for an available sample is {sample[15:0], 4'b0000}. It appears on slot_data in the cycle after the clock edge that sampled slot_req. Between requests, slot_data holds its last value.
- R4: A write (wr_en high with chan_en high) while 8 words are stored (the default depth) is dropped. overrun then goes high for one cycle after that edge, and the stored words are unchanged. In any other cycle overrun is low.
- R5: A slot request with chan_en high and no stored word makes slot_data zero. underrun then goes high for one cycle after that edge.
- R6: room_flag is high exactly when chan_en is high and the free space (depth minus stored words) is at least the burst size. The burst size equals the depth. room_flag is evaluated on the stored-word count after each edge.
- R7: dma_req goes high at the edge after room_flag is seen high while no request is pending and no cool-down cycle is running. It then stays high until dma_ack is sampled high or chan_en is sampled low.
- R8: After dma_ack is sampled with dma_req high, dma_req is low for at least one cycle. It rises again only if room_flag holds. A dma_ack sampled while dma_req is low has no effect.
- R9: An edge with chan_en low empties the FIFO and resets the half-word selector to the lower half. At such an edge, writes are not stored and raise no overrun. Slot requests at such an edge return zero and raise no underrun.
- R10: A write and a slot request that retires a word may take effect at the same edge. Whether the FIFO is full is judged on the occupancy before the retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; low flushes |
| wr_en | input | 1 | Word write strobe |
| wr_data | input | 32 | Packed sample pair, low half played first |
| slot_req | input | 1 | Frame logic asks for this channel's slot |
| slot_data | output | 20 | Formatted slot value |
| underrun | output | 1 | One-cycle pulse: slot asked with no sample |
| overrun | output | 1 | One-cycle pulse: write dropped at full FIFO |
| room_flag | output | 1 | Free space at least one burst |
| dma_req | output | 1 | Burst transfer request |
| dma_ack | input | 1 | One-cycle acknowledge of a finished burst |

## Verification
The bench aims at several corner cases, and each one shows a specific wrong design.
- The upper half of a word must come out after the lower half and retire the word. A design that swaps the halves, or retires on the first half, would repeat or skip samples.
- A write that lands on a full FIFO in the same cycle that a word is retired must still count as an overrun. A design that judges fullness after the pop would accept the word.
- The acknowledge must drop the request. A design that ignores it would hold dma_req high while the FIFO is full.
- A disable must clear the half-word selector. A design that keeps it would play the upper half of a fresh word first.

// File: rtl/pcm_out_pkg.sv
package pcm_out_pkg;

  // DMA handshake states
  typedef enum logic [1:0] {
    DMA_IDLE = 2'd0,
    DMA_ASK  = 2'd1,
    DMA_COOL = 2'd2
  } dma_st_t;

  // Words moved per service event for a given FIFO depth
  function automatic int burst_for(input int depth);
    return depth;
  endfunction

endpackage

// File: rtl/pcm_word_fifo.sv
module pcm_word_fifo #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] head,
  output logic [AW:0]       count
);

  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [AW-1:0]     wr_ptr_q, wr_ptr_nx;
  logic [AW-1:0]     rd_ptr_q, rd_ptr_nx;
  logic [AW:0]       cnt_q, cnt_nx;
  logic [WORD_W-1:0] cells [DEPTH];

  // storage: one register per entry, write enable decoded from the pointer
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [WORD_W-1:0] cell_q;
    logic              cell_we;
    assign cell_we = push && !flush && (wr_ptr_q == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= '0;
      else if (cell_we) cell_q <= wdata;
    end
    assign cells[i] = cell_q;
  end

  always_comb begin
    wr_ptr_nx = wr_ptr_q;
    rd_ptr_nx = rd_ptr_q;
    cnt_nx    = cnt_q;
    if (flush) begin
      wr_ptr_nx = '0;
      rd_ptr_nx = '0;
      cnt_nx    = '0;
    end else begin
      if (push) wr_ptr_nx = wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_nx = rd_ptr_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_nx = cnt_q + 1'b1;
        2'b01:   cnt_nx = cnt_q - 1'b1;
        default: cnt_nx = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_nx;
      rd_ptr_q <= rd_ptr_nx;
      cnt_q    <= cnt_nx;
    end
  end

  assign head  = cells[rd_ptr_q];
  assign count = cnt_q;

  // occupancy never exceeds the depth (full writes are dropped upstream)
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DEPTH_C);

  // a flush leaves the FIFO empty
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));

endmodule

// File: rtl/pcm_slot_fmt.sv
module pcm_slot_fmt #(
  parameter int SAMPLE_W = 16,
  parameter int PAD_W    = 4,
  localparam int WORD_W  = 2 * SAMPLE_W,
  localparam int SLOT_W  = SAMPLE_W + PAD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              slot_req,
  input  logic              empty,
  input  logic [WORD_W-1:0] head,
  output logic              pop,
  output logic [SLOT_W-1:0] slot_data,
  output logic              underrun
);

  logic              half_q, half_nx;
  logic [SLOT_W-1:0] slot_q, slot_nx;
  logic              und_q, und_nx;
  logic              take;
  logic [SAMPLE_W-1:0] sample;

  assign take   = slot_req && en && !empty;
  assign sample = half_q ? head[WORD_W-1:SAMPLE_W] : head[SAMPLE_W-1:0];
  assign pop    = take && half_q;

  always_comb begin
    half_nx = half_q;
    slot_nx = slot_q;
    und_nx  = slot_req && en && empty;
    if (!en)       half_nx = 1'b0;
    else if (take) half_nx = !half_q;
    if (slot_req) begin
      if (take) slot_nx = {sample, {PAD_W{1'b0}}};
      else      slot_nx = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      slot_q <= '0;
      und_q  <= 1'b0;
    end else begin
      half_q <= half_nx;
      slot_q <= slot_nx;
      und_q  <= und_nx;
    end
  end

  assign slot_data = slot_q;
  assign underrun  = und_q;

  // starved request yields a zero slot and an underrun pulse
  p_underrun_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && en && empty) |=> (slot_data == '0 && underrun));

  // pad bits are always zero
  p_zero_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_data[PAD_W-1:0] == '0);

  // a disabled channel answers requests quietly
  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !en) |=> (slot_data == '0 && !underrun));

endmodule

// File: rtl/pcm_dma_ctrl.sv
module pcm_dma_ctrl #(
  parameter int DEPTH = 8,
  parameter int BURST = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [AW:0] count,
  input  logic        dma_ack,
  output logic        room,
  output logic        dma_req
);

  import pcm_out_pkg::*;

  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);
  localparam logic [AW:0] BURST_C = (AW+1)'(BURST);

  dma_st_t     st_q, st_nx;
  logic [AW:0] free_w;

  assign free_w = DEPTH_C - count;
  assign room   = en && (free_w >= BURST_C);

  always_comb begin
    st_nx = st_q;
    case (st_q)
      DMA_IDLE: if (room) st_nx = DMA_ASK;
      DMA_ASK: begin
        if (!en)          st_nx = DMA_IDLE;
        else if (dma_ack) st_nx = DMA_COOL;
      end
      DMA_COOL: st_nx = DMA_IDLE;
      default:  st_nx = DMA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DMA_IDLE;
    else        st_q <= st_nx;
  end

  assign dma_req = (st_q == DMA_ASK);

  // acknowledge drops the request for at least one cycle
  p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack) |=> !dma_req);

  // request holds until acknowledged or disabled
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack && en) |=> dma_req);

  // a new request needs room seen the cycle before
  p_rise_room_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(room));

endmodule

// File: rtl/pcm_out_chan.sv
module pcm_out_chan #(
  parameter int DEPTH    = 8,
  parameter int SAMPLE_W = 16,
  parameter int PAD_W    = 4,
  localparam int WORD_W  = 2 * SAMPLE_W,
  localparam int SLOT_W  = SAMPLE_W + PAD_W,
  localparam int AW      = $clog2(DEPTH),
  localparam int BURST   = pcm_out_pkg::burst_for(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              slot_req,
  output logic [SLOT_W-1:0] slot_data,
  output logic              underrun,
  output logic              overrun,
  output logic              room_flag,
  output logic              dma_req,
  input  logic              dma_ack
);

  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  logic [AW:0]       count;
  logic [WORD_W-1:0] head;
  logic              full, empty, push, pop, flush;
  logic              ovr_q, ovr_nx;

  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);
  assign flush = !chan_en;
  assign push  = wr_en && chan_en && !full;

  always_comb ovr_nx = wr_en && chan_en && full;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) ovr_q <= 1'b0;
    else             ovr_q <= ovr_nx;
  end
  assign overrun = ovr_q;

  pcm_word_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_core_n),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .wdata (wr_data),
    .head  (head),
    .count (count)
  );

  pcm_slot_fmt #(.SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W)) u_fmt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .en        (chan_en),
    .slot_req  (slot_req),
    .empty     (empty),
    .head      (head),
    .pop       (pop),
    .slot_data (slot_data),
    .underrun  (underrun)
  );

  pcm_dma_ctrl #(.DEPTH(DEPTH), .BURST(BURST)) u_dma (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .en      (chan_en),
    .count   (count),
    .dma_ack (dma_ack),
    .room    (room_flag),
    .dma_req (dma_req)
  );

  // a write into a full FIFO is reported next cycle
  p_overrun_flag_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && chan_en && full) |=> overrun);

  // nothing is flagged on a cycle after a disabled edge
  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !chan_en |=> (!overrun && !underrun));

endmodule

// File: tb/test_pcm_out_chan.sv
module test_pcm_out_chan;

  localparam int D = 8;

  logic        clk, rst_n;
  logic        chan_en, wr_en, slot_req, dma_ack;
  logic [31:0] wr_data;
  logic [19:0] slot_data;
  logic        underrun, overrun, room_flag, dma_req;

  int n_chk, n_fail;

  // reference model state
  logic [31:0] mq[$];
  bit          mhalf;
  int          mst;        // 0 idle, 1 ask, 2 cool
  logic [19:0] e_slot;
  logic        e_under, e_over;

  pcm_out_chan #(.DEPTH(D)) i_pcm_out_chan (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr_en(wr_en),
    .wr_data(wr_data), .slot_req(slot_req), .slot_data(slot_data),
    .underrun(underrun), .overrun(overrun), .room_flag(room_flag),
    .dma_req(dma_req), .dma_ack(dma_ack)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] fmt(input logic [15:0] s);
    return {s, 4'h0};
  endfunction

  // one cycle: drive at negedge, model the edge, check at next negedge
  task automatic step(input logic en, input logic wr, input logic [31:0] wd,
                      input logic req, input logic ack);
    int sz;
    logic roomp;
    logic [15:0] s;
    chan_en = en; wr_en = wr; wr_data = wd; slot_req = req; dma_ack = ack;
    sz    = mq.size();
    roomp = en && ((D - sz) >= D);
    case (mst)
      0: if (roomp) mst = 1;
      1: if (!en) mst = 0; else if (ack) mst = 2;
      default: mst = 0;
    endcase
    e_over  = wr && en && (sz == D);
    e_under = req && en && (sz == 0);
    if (req) begin
      if (en && sz > 0) begin
        s = mhalf ? mq[0][31:16] : mq[0][15:0];
        e_slot = fmt(s);
        if (mhalf) void'(mq.pop_front());
        mhalf = !mhalf;
      end else e_slot = '0;
    end
    if (!en) begin
      mq.delete();
      mhalf = 1'b0;
    end else if (wr && sz < D) mq.push_back(wd);
    @(posedge clk);
    @(negedge clk);
    chk(slot_data === e_slot, e_under ? "R5 slot" : "R3 slot", 32'(slot_data), 32'(e_slot));
    chk(underrun === e_under, "R5 underrun", 32'(underrun), 32'(e_under));
    chk(overrun === e_over, "R4 overrun", 32'(overrun), 32'(e_over));
    chk(room_flag === (en && mq.size() == 0), "R6 room", 32'(room_flag),
        32'(en && mq.size() == 0));
    chk(dma_req === (mst == 1), "R7 dma_req", 32'(dma_req), 32'(mst == 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    mhalf = 0; mst = 0; e_slot = '0; e_under = 0; e_over = 0;
    void'($urandom(32'h5A17_C0DE));
    rst_n = 0; chan_en = 0; wr_en = 0; slot_req = 0; dma_ack = 0; wr_data = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(slot_data === '0, "R1 slot", 32'(slot_data), 0);
    chk(!underrun && !overrun, "R1 flags", {underrun, overrun}, 0);
    chk(!room_flag, "R1 room", 32'(room_flag), 0);
    chk(!dma_req, "R1 dma_req", 32'(dma_req), 0);

    // R6/R7: enable on empty FIFO -> room, then request
    step(1, 0, 0, 0, 0);
    // burst of D words while request pending
    for (int i = 0; i < D; i++) step(1, 1, 32'hA000_0000 + 32'(i * 32'h0001_0101), 0, 0);
    chk(dma_req === 1'b1, "R7 held until ack", 32'(dma_req), 1);
    step(1, 0, 0, 0, 1);
    chk(dma_req === 1'b0, "R8 dropped after ack", 32'(dma_req), 0);
    step(1, 0, 0, 0, 0);
    chk(dma_req === 1'b0, "R8 no reassert while full", 32'(dma_req), 0);
    step(1, 0, 0, 0, 1);   // R8: stray ack ignored
    // R4: write to full FIFO is dropped
    step(1, 1, 32'hDEAD_BEEF, 0, 0);
    // R2/R3: drain, low half then high half, then underrun (R5)
    for (int i = 0; i < 2 * D + 1; i++) step(1, 0, 0, 1, 0);

    // R10: refill, retire a word while a write lands on the full FIFO
    for (int i = 0; i < D; i++) step(1, 1, 32'h1234_0000 + 32'(i), 0, 0);
    step(1, 0, 0, 1, 0);
    step(1, 1, 32'hCAFE_F00D, 1, 0);   // pop and write same edge: overrun (R10)
    for (int i = 0; i < 2 * D; i++) step(1, 0, 0, 1, 0);

    // R9: flush mid-word, then the new word starts at its low half
    step(1, 1, 32'h1111_2222, 0, 0);
    step(1, 1, 32'h3333_4444, 0, 0);
    step(1, 0, 0, 1, 0);
    step(0, 1, 32'h5555_6666, 1, 0);
    step(1, 1, 32'h7777_8888, 0, 0);
    step(1, 0, 0, 1, 0);
    chk(slot_data === 20'h88880, "R9 low half after flush", 32'(slot_data), 32'h88880);

    // random traffic with phases biased toward filling or draining
    for (int ph = 0; ph < 16; ph++) begin
      int wp, rp;
      wp = (ph % 2 == 0) ? 70 : 25;
      rp = (ph % 2 == 0) ? 30 : 80;
      for (int c = 0; c < 200; c++) begin
        logic en, wr, rq, ak;
        en = ($urandom % 25) != 0;
        wr = ($urandom % 100) < wp;
        rq = ($urandom % 100) < rp;
        ak = dma_req ? (($urandom % 4) == 0) : (($urandom % 16) == 0);
        step(en, wr, $urandom, rq, ak);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule